// File: doc/BRIEF.md
# Interrupt Request and Acknowledge Sequencer

This block sits beside a processor core and turns two interrupt lines into a single vector handed to the core. The maskable line is level-sensitive and only counts while the core's interrupt-enable flag is set. The non-maskable line is edge-triggered: a rising edge sets a pending latch, and the line does nothing more until it has fallen and risen again. Both lines are brought into the clock domain through a configurable synchronizer. The non-maskable latch is held in the synchronized domain, so holding the line high causes no further requests.

The core raises `core_ready` at an instruction boundary when it can take an interrupt. In that cycle the sequencer picks the winner, and a pending non-maskable request always wins. A non-maskable request is delivered at once with the fixed vector 2. A maskable request starts two back-to-back interrupt-acknowledge bus cycles through a request/done handshake. The vector is the low byte of the bus data at the completion of the second cycle. Delivery is a one-cycle `vec_valid` pulse, after which the sequencer is idle again.

States: `ST_IDLE` (waiting for acceptance), `ST_ACK1` (first acknowledge cycle), `ST_ACK2` (second acknowledge cycle, vector capture), `ST_DELIVER` (vector-valid pulse). Transitions: `ST_IDLE`→`ST_DELIVER` on non-maskable acceptance; `ST_IDLE`→`ST_ACK1` on maskable acceptance; `ST_ACK1`→`ST_ACK2` on `bus_done`; `ST_ACK2`→`ST_DELIVER` on `bus_done`; `ST_DELIVER`→`ST_IDLE` always. Every other case holds the current state.

Top module: `irq_ack_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bus_req`, `vec_valid` and `irq_pending` are 0.
- R2: Each rising edge of `nmi_in` gives exactly one delivery. Holding the line high gives no further ones. A line that is already high when reset is released is not treated as an edge.
- R3: A non-maskable delivery carries vector 2 with `vec_is_nmi`=1 and runs no bus cycle (`bus_req` stays 0).
- R4: While `if_flag`=0, `intr_in` has no effect: `bus_req`, `vec_valid` and `irq_pending` stay 0.
- R5: An enabled maskable request is held pending, with `irq_pending`=1 and no bus activity, until `core_ready`=1 accepts it. A bus cycle starts only after such an acceptance.
- R6: A maskable acceptance runs exactly two acknowledge cycles: `ack_phase`=0 and then `ack_phase`=1. `bus_req` stays high without a gap from the start of the first cycle to the `bus_done` of the second, and holds while `bus_done` is 0.
- R7: The delivered maskable vector equals `bus_data[7:0]` sampled with `bus_done` in the second cycle, with `vec_is_nmi`=0. Data returned in the first cycle is ignored.
- R8: When both requests are pending at acceptance, the non-maskable one is delivered first. The maskable one follows if its line is still asserted.
- R9: A maskable line that drops before acceptance causes no acknowledge cycles and no delivery.
- R10: `vec_valid` is a single-cycle pulse, and the cycle after it has `bus_req`=0.
- R11: A non-maskable edge arriving during a maskable sequence stays latched. It is delivered after the maskable vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_in | input | 1 | Non-maskable request, edge-triggered, asynchronous |
| intr_in | input | 1 | Maskable request, level, asynchronous |
| if_flag | input | 1 | Interrupt-enable flag from the core |
| core_ready | input | 1 | Core can accept an interrupt this cycle |
| irq_pending | output | 1 | An acceptable request is waiting |
| bus_req | output | 1 | Acknowledge bus cycle requested |
| ack_phase | output | 1 | 0 = first, 1 = second acknowledge cycle |
| bus_done | input | 1 | Bus cycle completes this cycle |
| bus_data | input | DATA_W (32) | Bus read data; vector in bits 7:0 |
| vec_valid | output | 1 | One-cycle vector delivery pulse |
| vec_out | output | VEC_W (8) | Delivered vector |
| vec_is_nmi | output | 1 | Delivered vector came from the non-maskable line |

## Verification
The two functions that can fall in the same cycle are the choice between requests at acceptance and a new non-maskable edge reaching the latch. The first case is provoked by raising both lines while `core_ready` is low and then raising it. The bench expects the first delivery to be vector 2 and the second to be the bus-supplied byte. The second case is provoked by pulsing `nmi_in` while a slow bus responder holds the first acknowledge cycle open. The bench expects the maskable vector to arrive first, then exactly one non-maskable delivery, with exactly two acknowledge handshakes in total.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACK1    = 2'd1,
        ST_ACK2    = 2'd2,
        ST_DELIVER = 2'd3
    } seq_state_t;

    localparam int DEF_VEC_W   = 8;
    localparam int DEF_DATA_W  = 32;
    localparam int DEF_NMI_VEC = 2;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign d_out = d_in;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q <= {STAGES{RST_VAL}};
                end else if (STAGES == 1) begin
                    chain_q[0] <= d_in;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], d_in};
                end
            end
            assign d_out = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic line_s,
    input  logic take,
    output logic pend
);

    logic line_q;
    logic rise;

    // Reset the previous value high so that a line held through reset is not an edge.
    assign rise = line_s & ~line_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= 1'b1;
            pend   <= 1'b0;
        end else begin
            line_q <= line_s;
            if (rise) begin
                pend <= 1'b1;
            end else if (take) begin
                pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_seq_pkg::*;
#(
    parameter int VEC_W   = DEF_VEC_W,
    parameter int DATA_W  = DEF_DATA_W,
    parameter int NMI_VEC = DEF_NMI_VEC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_pend,
    input  logic              intr_s,
    input  logic              if_flag,
    input  logic              core_ready,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_data,
    output logic              nmi_take,
    output logic              bus_req,
    output logic              ack_phase,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vec_out,
    output logic              vec_is_nmi
);

    localparam logic [VEC_W-1:0] NMI_CODE = VEC_W'(NMI_VEC);

    seq_state_t       state_q, state_d;
    logic [VEC_W-1:0] vec_q;
    logic             nmi_q;
    logic             take_intr;
    logic             capture;

    // Arbitration at the acceptance point: non-maskable first.
    always_comb begin
        nmi_take  = 1'b0;
        take_intr = 1'b0;
        if (state_q == ST_IDLE && core_ready) begin
            if (nmi_pend) begin
                nmi_take = 1'b1;
            end else if (intr_s && if_flag) begin
                take_intr = 1'b1;
            end
        end
    end

    assign capture = (state_q == ST_ACK2) && bus_done;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (nmi_take) begin
                    state_d = ST_DELIVER;
                end else if (take_intr) begin
                    state_d = ST_ACK1;
                end
            end
            ST_ACK1: begin
                if (bus_done) begin
                    state_d = ST_ACK2;
                end
            end
            ST_ACK2: begin
                if (bus_done) begin
                    state_d = ST_DELIVER;
                end
            end
            ST_DELIVER: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register together with the vector it will deliver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
            nmi_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (nmi_take) begin
                vec_q <= NMI_CODE;
                nmi_q <= 1'b1;
            end else if (capture) begin
                vec_q <= bus_data[VEC_W-1:0];
                nmi_q <= 1'b0;
            end
        end
    end

    // Moore outputs.
    always_comb begin
        bus_req    = 1'b0;
        ack_phase  = 1'b0;
        vec_valid  = 1'b0;
        vec_out    = '0;
        vec_is_nmi = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_ACK1: begin
                bus_req = 1'b1;
            end
            ST_ACK2: begin
                bus_req   = 1'b1;
                ack_phase = 1'b1;
            end
            ST_DELIVER: begin
                vec_valid  = 1'b1;
                vec_out    = vec_q;
                vec_is_nmi = nmi_q;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
    import irq_seq_pkg::*;
#(
    parameter int VEC_W       = DEF_VEC_W,
    parameter int DATA_W      = DEF_DATA_W,
    parameter int NMI_VEC     = DEF_NMI_VEC,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_in,
    input  logic              intr_in,
    input  logic              if_flag,
    input  logic              core_ready,
    output logic              irq_pending,
    output logic              bus_req,
    output logic              ack_phase,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_data,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vec_out,
    output logic              vec_is_nmi
);

    logic nmi_s;
    logic intr_s;
    logic nmi_pend;
    logic nmi_take;

    irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_nmi (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (nmi_in),
        .d_out (nmi_s)
    );

    irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_intr (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (intr_in),
        .d_out (intr_s)
    );

    irq_nmi_edge u_nmi_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_s (nmi_s),
        .take   (nmi_take),
        .pend   (nmi_pend)
    );

    irq_ack_fsm #(
        .VEC_W   (VEC_W),
        .DATA_W  (DATA_W),
        .NMI_VEC (NMI_VEC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .nmi_pend   (nmi_pend),
        .intr_s     (intr_s),
        .if_flag    (if_flag),
        .core_ready (core_ready),
        .bus_done   (bus_done),
        .bus_data   (bus_data),
        .nmi_take   (nmi_take),
        .bus_req    (bus_req),
        .ack_phase  (ack_phase),
        .vec_valid  (vec_valid),
        .vec_out    (vec_out),
        .vec_is_nmi (vec_is_nmi)
    );

    assign irq_pending = nmi_pend | (intr_s & if_flag);

endmodule

// File: rtl/irq_ack_seq_chk.sv
module irq_ack_seq_chk #(
    parameter int VEC_W   = 8,
    parameter int DATA_W  = 32,
    parameter int NMI_VEC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              if_flag,
    input logic              core_ready,
    input logic              intr_s,
    input logic              bus_req,
    input logic              ack_phase,
    input logic              bus_done,
    input logic [DATA_W-1:0] bus_data,
    input logic              vec_valid,
    input logic [VEC_W-1:0]  vec_out,
    input logic              vec_is_nmi
);

    assert_nmi_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid && vec_is_nmi |-> vec_out == VEC_W'(NMI_VEC));

    assert_start_needs_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(intr_s && if_flag && core_ready));

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_done |=> bus_req && ack_phase == $past(ack_phase));

    assert_phase_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_done && !ack_phase |=> bus_req && ack_phase);

    assert_vector_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_done && ack_phase |=>
            vec_valid && !vec_is_nmi && vec_out == $past(bus_data[VEC_W-1:0]));

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid && !bus_req);

endmodule

bind irq_ack_seq irq_ack_seq_chk #(
    .VEC_W   (VEC_W),
    .DATA_W  (DATA_W),
    .NMI_VEC (NMI_VEC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .if_flag    (if_flag),
    .core_ready (core_ready),
    .intr_s     (intr_s),
    .bus_req    (bus_req),
    .ack_phase  (ack_phase),
    .bus_done   (bus_done),
    .bus_data   (bus_data),
    .vec_valid  (vec_valid),
    .vec_out    (vec_out),
    .vec_is_nmi (vec_is_nmi)
);

// File: tb/test_irq_ack_seq.sv
module test_irq_ack_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_in = 1'b0, intr_in = 1'b0, if_flag = 1'b0, core_ready = 1'b0;
    logic        irq_pending, bus_req, ack_phase, vec_valid, vec_is_nmi;
    logic        bus_done = 1'b0;
    logic [31:0] bus_data = '0;
    logic [7:0]  vec_out;

    int n_cmp = 0, n_bad = 0;
    bit done_flag = 0;

    // monitor state
    int vv_n = 0, vv_double = 0, req_cycles = 0, req_rise = 0;
    logic [7:0] v0, v1;
    logic n0, n1;
    logic vv_prev = 0, req_prev = 0;
    // responder state
    int resp_wait = 2, wcnt = 0, ack0_n = 0, ack1_n = 0, order_bad = 0;
    logic [7:0] resp_vec = 8'h40;

    always #10 clk = ~clk;

    irq_ack_seq i_irq_ack_seq (
        .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .intr_in(intr_in),
        .if_flag(if_flag), .core_ready(core_ready), .irq_pending(irq_pending),
        .bus_req(bus_req), .ack_phase(ack_phase), .bus_done(bus_done),
        .bus_data(bus_data), .vec_valid(vec_valid), .vec_out(vec_out),
        .vec_is_nmi(vec_is_nmi)
    );

    always @(negedge clk) begin
        if (vec_valid) begin
            if (vv_n == 0) begin v0 = vec_out; n0 = vec_is_nmi; end
            else if (vv_n == 1) begin v1 = vec_out; n1 = vec_is_nmi; end
            vv_n++;
            if (vv_prev) vv_double++;
        end
        vv_prev = vec_valid;
        if (bus_req) req_cycles++;
        if (bus_req && !req_prev) req_rise++;
        req_prev = bus_req;
        // bus responder: first-cycle low byte is 0xEE, second carries resp_vec
        if (bus_done) begin
            bus_done = 1'b0;
            wcnt = 0;
        end else if (bus_req) begin
            if (wcnt >= resp_wait) begin
                bus_done = 1'b1;
                if (ack_phase) begin
                    bus_data = {24'hC3C3C3, resp_vec};
                    if (ack0_n <= ack1_n) order_bad++;
                    ack1_n++;
                end else begin
                    bus_data = 32'h5A5A5AEE;
                    ack0_n++;
                end
            end else begin
                wcnt++;
            end
        end else begin
            wcnt = 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clr();
        vv_n = 0; vv_double = 0; req_cycles = 0; req_rise = 0;
        ack0_n = 0; ack1_n = 0; order_bad = 0;
    endtask

    task automatic wait_req();
        for (int i = 0; i < 60; i++) begin
            if (bus_req) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        nmi_in = 1'b1;
        cyc(3);
        chk("R1 bus_req in reset", bus_req, 0);
        chk("R1 vec_valid in reset", vec_valid, 0);
        chk("R1 irq_pending in reset", irq_pending, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 bus_req after reset", bus_req, 0);
        chk("R1 irq_pending after reset", irq_pending, 0);
        core_ready = 1'b1;
        clr();
        cyc(10);
        chk("R2 line high through reset", vv_n, 0);
        nmi_in = 1'b0;
        cyc(4);
    endtask

    task automatic t_nmi();
        clr();
        core_ready = 1'b1;
        nmi_in = 1'b1;
        cyc(20);
        chk("R2 one delivery per edge", vv_n, 1);
        chk("R3 nmi vector", v0, 8'd2);
        chk("R3 nmi flag", n0, 1);
        chk("R3 no bus cycles", req_cycles, 0);
        nmi_in = 1'b0;
        cyc(4);
        nmi_in = 1'b1;
        cyc(10);
        chk("R2 second edge delivers", vv_n, 2);
        nmi_in = 1'b0;
        cyc(4);
    endtask

    task automatic t_masked();
        clr();
        if_flag = 1'b0;
        core_ready = 1'b1;
        intr_in = 1'b1;
        cyc(6);
        chk("R4 irq_pending masked", irq_pending, 0);
        cyc(10);
        chk("R4 no bus cycle masked", req_cycles, 0);
        chk("R4 no delivery masked", vv_n, 0);
        intr_in = 1'b0;
        cyc(4);
    endtask

    task automatic t_pending_and_ack(input logic [7:0] vec, input int wt);
        clr();
        resp_vec = vec;
        resp_wait = wt;
        if_flag = 1'b1;
        core_ready = 1'b0;
        intr_in = 1'b1;
        cyc(8);
        chk("R5 pending held", irq_pending, 1);
        chk("R5 no bus before accept", req_cycles, 0);
        core_ready = 1'b1;
        wait_req();
        intr_in = 1'b0;
        cyc(30);
        chk("R6 first-phase handshakes", ack0_n, 1);
        chk("R6 second-phase handshakes", ack1_n, 1);
        chk("R6 phase order", order_bad, 0);
        chk("R6 bus_req contiguous", req_rise, 1);
        chk("R7 captured vector", v0, vec);
        chk("R7 maskable flag", n0, 0);
        chk("R10 single pulse", vv_double, 0);
        chk("R10 single delivery", vv_n, 1);
        chk("R10 idle after pulse", bus_req, 0);
    endtask

    task automatic t_drop();
        clr();
        if_flag = 1'b1;
        core_ready = 1'b0;
        intr_in = 1'b1;
        cyc(4);
        intr_in = 1'b0;
        cyc(5);
        core_ready = 1'b1;
        cyc(10);
        chk("R9 no bus after drop", req_cycles, 0);
        chk("R9 no delivery after drop", vv_n, 0);
    endtask

    task automatic t_prio();
        clr();
        resp_vec = 8'h77;
        resp_wait = 1;
        if_flag = 1'b1;
        core_ready = 1'b0;
        intr_in = 1'b1;
        nmi_in = 1'b1;
        cyc(8);
        core_ready = 1'b1;
        wait_req();
        intr_in = 1'b0;
        cyc(20);
        chk("R8 deliveries", vv_n, 2);
        chk("R8 first is nmi", v0, 8'd2);
        chk("R8 first flag", n0, 1);
        chk("R8 second is maskable", v1, 8'h77);
        nmi_in = 1'b0;
        cyc(4);
    endtask

    task automatic t_nmi_during();
        clr();
        resp_vec = 8'h19;
        resp_wait = 6;
        if_flag = 1'b1;
        core_ready = 1'b1;
        intr_in = 1'b1;
        wait_req();
        intr_in = 1'b0;
        nmi_in = 1'b1;
        cyc(3);
        nmi_in = 1'b0;
        cyc(40);
        chk("R11 deliveries", vv_n, 2);
        chk("R11 maskable first", v0, 8'h19);
        chk("R11 nmi second", v1, 8'd2);
        chk("R11 nmi flag", n1, 1);
        chk("R11 two handshakes", ack0_n + ack1_n, 2);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_nmi();
        t_masked();
        t_pending_and_ack(8'h40, 2);
        t_pending_and_ack(8'hFF, 0);
        t_pending_and_ack(8'h00, 5);
        t_drop();
        t_prio();
        t_nmi_during();
        finish_run();
    end

endmodule